// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block holds a word of parameterised width (eight stages by default). It either takes the whole word at once from a parallel data bus or moves it one stage toward the last stage on each effective shift edge. A serial data bit enters the first stage on every shift. The last stage drives the serial output, and a companion output carries the inverse of that stage. Typical uses are serialising a captured parallel word and chaining words through the serial input.

The shift edge comes from two external clock-type lines that are combined through a NOR. Either line held high blocks shifting, so either one can serve as the inhibit for the other. All logic runs on one free-running system clock. Both external lines pass through a two-flop synchroniser. A shift takes place in the system cycle after the synchronised NOR falls, which is the same as the OR of the two lines rising. The load input is active low and level sensitive. It is sampled on every system clock, and it overrides any shift that is detected in the same cycle.

A synchronous active-high reset clears all stages.

Top module: `gated_piso_shift`

## Requirements
- R1: After a synchronous reset every stage is 0, so `q_last` reads 0 and `q_last_n` reads 1.
- R2: While `load_n` is low, every stage i takes `par_in[i]` on each system clock, whatever the levels on `ck_a`, `ck_b` and `ser_in`. Bit 0 is the first stage, and bit WIDTH-1 is the last stage, which drives `q_last`.
- R3: A shift edge detected while `load_n` is low has no effect. The register ends up equal to `par_in`.
- R4: With `load_n` high and `ck_b` low, a rise of `ck_a` shifts exactly once. Stage 0 takes `ser_in` and stage i takes the old stage i-1.
- R5: While either clock line is held high, any number of toggles on the other line produce no shift.
- R6: The two lines are interchangeable. With `ck_a` low, a rise of `ck_b` shifts exactly once.
- R7: A line that rises while the other line is low produces a shift, even when that line is meant as the inhibit. A line that rises while the other is already high does not.
- R8: With `load_n` high and both lines steady, the contents are held for any number of cycles.
- R9: `q_last_n` is always the inverse of `q_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| par_in | input | WIDTH | Parallel data; bit 0 goes to the first stage |
| ser_in | input | 1 | Serial data into the first stage |
| ck_a | input | 1 | External shift-clock line A (asynchronous) |
| ck_b | input | 1 | External shift-clock line B (asynchronous) |
| q_last | output | 1 | Last stage, true polarity |
| q_last_n | output | 1 | Last stage, inverted |

## Verification
Words with uneven bit patterns are loaded and then read out one bit at a time through the serial output. This separates a correct stage order from a reversed or stuck one. A separate serial pattern is shifted in and read back, which shows that the serial input feeds the first stage. The two lines are driven in several orders: clocking on either line, toggling one line while the other is held high, raising the inhibit while the clock is low or high, and clocking while the load is held low. A full readout after each of these tells real shifts apart from suppressed ones. A long idle stretch before a readout checks that the contents are held.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } piso_mode_e;

  // Level of the combined shift clock: high only when both lines are low.
  function automatic logic f_nor2(input logic a, input logic b);
    return ~(a | b);
  endfunction

  // Next-state selector: load overrides a shift pulse, otherwise hold.
  function automatic piso_mode_e f_mode(input logic load_n, input logic pulse);
    if (!load_n)    return MODE_LOAD;
    else if (pulse) return MODE_SHIFT;
    else            return MODE_HOLD;
  endfunction

endpackage

// File: rtl/piso_line_sync.sv
module piso_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  logic [LINES-1:0] chain [STAGES];

  // No reset: the chain keeps sampling during reset so the edge detector
  // leaves reset already aligned with the real line levels.
  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int s = 1; s < STAGES; s++) begin
      chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/piso_edge_detect.sv
module piso_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_a,
  input  logic ck_b,
  output logic shift_pulse
);

  logic [1:0] lines_sync;
  logic       nor_lvl;
  logic       nor_prev;

  piso_line_sync #(
    .LINES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .d   ({ck_b, ck_a}),
    .q   (lines_sync)
  );

  assign nor_lvl = piso_pkg::f_nor2(lines_sync[0], lines_sync[1]);

  always_ff @(posedge clk) begin
    nor_prev <= nor_lvl;
  end

  // Falling edge of the combined NOR clock == rising edge of either line
  // while the other one is low.
  assign shift_pulse = !rst && nor_prev && !nor_lvl;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> !shift_pulse);  // R4

  AST_INHIBIT_B: assert property (@(posedge clk) disable iff (rst)
    (lines_sync[1] && $past(lines_sync[1])) |-> !shift_pulse);  // R5

  AST_INHIBIT_A: assert property (@(posedge clk) disable iff (rst)
    (lines_sync[0] && $past(lines_sync[0])) |-> !shift_pulse);  // R5

endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             shift_pulse,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stage_q
);
  import piso_pkg::*;

  localparam int LAST = WIDTH - 1;

  piso_mode_e       mode;
  logic [WIDTH-1:0] next_q;

  assign mode = f_mode(load_n, shift_pulse);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_prev;
    if (i == 0) begin : g_first
      assign from_prev = ser_in;
    end else begin : g_rest
      assign from_prev = stage_q[i-1];
    end
    always_comb begin
      case (mode)
        MODE_LOAD:  next_q[i] = par_in[i];
        MODE_SHIFT: next_q[i] = from_prev;
        default:    next_q[i] = stage_q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= next_q;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stage_q == '0));  // R1

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (stage_q == $past(par_in)));  // R2

  AST_LOAD_OVER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!load_n && shift_pulse) |=> (stage_q == $past(par_in)));  // R3

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (load_n && shift_pulse) |=>
      (stage_q[0] == $past(ser_in)) &&
      (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));  // R4

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (load_n && !shift_pulse) |=> $stable(stage_q));  // R8

endmodule

// File: rtl/gated_piso_shift.sv
module gated_piso_shift #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             ck_a,
  input  logic             ck_b,
  output logic             q_last,
  output logic             q_last_n
);

  logic             shift_pulse;
  logic [WIDTH-1:0] stage_q;

  piso_edge_detect #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk         (clk),
    .rst         (rst),
    .ck_a        (ck_a),
    .ck_b        (ck_b),
    .shift_pulse (shift_pulse)
  );

  piso_stages #(
    .WIDTH (WIDTH)
  ) u_stages (
    .clk         (clk),
    .rst         (rst),
    .load_n      (load_n),
    .shift_pulse (shift_pulse),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .stage_q     (stage_q)
  );

  assign q_last   = stage_q[WIDTH-1];
  assign q_last_n = ~stage_q[WIDTH-1];

  AST_OUT_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (q_last == $past(par_in[WIDTH-1])) && (q_last_n != q_last));  // R9

endmodule

// File: tb/gated_piso_shift_tb.sv
module gated_piso_shift_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_n;
  logic [W-1:0] par_in;
  logic         ser_in;
  logic         ck_a;
  logic         ck_b;
  logic         q_last;
  logic         q_last_n;

  always #2 clk = ~clk;  // 250 MHz

  gated_piso_shift #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .ck_a     (ck_a),
    .ck_b     (ck_b),
    .q_last   (q_last),
    .q_last_n (q_last_n)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t        exp_q[$];
  int           checks   = 0;
  int           failures = 0;
  bit           done     = 0;
  logic [W-1:0] mdl;

  // Monitor: pops expectations and compares against the outputs.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (q_last !== it.exp) begin
        failures++;
        $display("FAIL %s q_last=%b expected=%b", it.tag, q_last, it.exp);
      end
      checks++;
      if (q_last_n !== ~it.exp) begin
        failures++;
        $display("FAIL %s/R9 q_last_n=%b expected=%b", it.tag, q_last_n, ~it.exp);
      end
    end
  end

  task automatic expect_last(input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.exp = mdl[W-1];
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Drive both lines and the serial bit; the model shifts when the OR rises.
  task automatic drive_lines(input logic a, input logic b, input logic s);
    logic old_or;
    @(negedge clk);
    old_or = ck_a | ck_b;
    ck_a   = a;
    ck_b   = b;
    ser_in = s;
    if (!old_or && (a | b) && load_n) mdl = {mdl[W-2:0], s};
    repeat (8) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] p);
    @(negedge clk);
    load_n = 1'b0;
    par_in = p;
    mdl    = p;
    repeat (3) @(negedge clk);
    load_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Reads all stages through the serial output; needs ck_b low.
  task automatic readout(input string tag);
    for (int i = 0; i < W; i++) begin
      expect_last(tag);
      drive_lines(1'b1, 1'b0, 1'b0);
      drive_lines(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    rst = 1'b1; load_n = 1'b1; par_in = '0; ser_in = 1'b0;
    ck_a = 1'b0; ck_b = 1'b0; mdl = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    expect_last("R1 reset state");

    // R2: parallel load then ordered readout (R4)
    load_word(8'b1011_0010);
    expect_last("R2 load");
    readout("R4 readout after load");

    // R4: serial entry into first stage
    for (int i = 0; i < W; i++) begin
      drive_lines(1'b1, 1'b0, 8'hC9 >> i);
      drive_lines(1'b0, 1'b0, 1'b0);
    end
    readout("R4 serial entry");

    // R3: clock edges while load held low
    @(negedge clk);
    load_n = 1'b0; par_in = 8'h6E; mdl = 8'h6E;
    for (int i = 0; i < 3; i++) begin
      drive_lines(1'b1, 1'b0, 1'b1);
      drive_lines(1'b0, 1'b0, 1'b1);
    end
    load_n = 1'b1;
    readout("R3 load priority");

    // R5: ck_b held high inhibits ck_a toggles
    load_word(8'h5A);
    drive_lines(1'b1, 1'b0, 1'b0);
    drive_lines(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      drive_lines(1'b0, 1'b1, 1'b1);
      drive_lines(1'b1, 1'b1, 1'b1);
    end
    drive_lines(1'b1, 1'b0, 1'b0);
    drive_lines(1'b0, 1'b0, 1'b0);
    readout("R5 inhibit by ck_b");

    // R5: ck_a held high inhibits ck_b toggles
    load_word(8'h3C);
    drive_lines(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      drive_lines(1'b1, 1'b1, 1'b1);
      drive_lines(1'b1, 1'b0, 1'b1);
    end
    drive_lines(1'b0, 1'b0, 1'b0);
    readout("R5 inhibit by ck_a");

    // R6: ck_b used as the clock
    load_word(8'h81);
    for (int i = 0; i < 3; i++) begin
      drive_lines(1'b0, 1'b1, 1'b1);
      drive_lines(1'b0, 1'b0, 1'b1);
    end
    readout("R6 clock on ck_b");

    // R7: raising inhibit while clock low is a shift edge
    load_word(8'hF0);
    drive_lines(1'b0, 1'b1, 1'b1);
    drive_lines(1'b1, 1'b1, 1'b0);
    drive_lines(1'b0, 1'b1, 1'b0);
    drive_lines(1'b0, 1'b0, 1'b0);
    readout("R7 false edge");

    // R8: long hold
    load_word(8'h96);
    repeat (60) @(negedge clk);
    readout("R8 hold");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule